// File: doc/BRIEF.md
# Divided Countdown Timer With Interrupt Vector

This block is a local countdown timer for one processor's interrupt unit. Software loads a start value into a reload register. The timer then counts down once per divided tick. The tick rate is the input clock divided by a power of two, and the power is chosen through a divide register. When the count runs out, the block raises a one-cycle interrupt request that carries an 8-bit vector. That request is an edge-triggered, fixed-delivery event. The timer then either stops at zero (one-shot) or reloads and runs again (periodic).

A 32-bit word-addressed register port gives access to the following:
- a configuration word holding the software enable;
- the divide register;
- the reload register;
- a read-only current-count register;
- six vector entries.

Entry 0 is the timer's own entry. It holds the vector, a mask bit and a periodic bit. The other five entries only store a vector and a mask. They are kept so that the enable and mask rules behave the same across the whole table. A hardware enable input gates delivery together with the software enable.

Top module: `vtimer`

## Requirements
- R1: After reset, the configuration, divide, reload and current-count registers read 0, every entry reads 0x0001_0000 (mask bit 16 set), and no request is raised.
- R2: The divide code is {bit 3, bit 1, bit 0} of the divide register (word 1). The divisor is 2^((code+1) mod 8), so codes 0..6 divide by 2..128 and code 7 divides by 1. Bit 2 has no effect on the rate.
- R3: A write to the reload register (word 2) with value N>0 cancels any running count and restarts from N with a fresh prescaler. The request appears exactly N*D cycles after the write edge, where D is the divisor.
- R4: The current count (word 3) drops by one per divided tick. In one-shot mode (bit 17 of entry 0 clear) it stays at 0 after expiry, and no further request follows.
- R5: In periodic mode (bit 17 of entry 0 set), expiry reloads the reload value, and requests repeat every N*D cycles.
- R6: A request is a single-cycle irq_valid pulse with irq_vector equal to bits 7:0 of entry 0. It fires only when unit_en is high, the software enable (bit 0 of word 0) is set, and mask bit 16 of entry 0 is clear. A suppressed expiry still ends the count.
- R7: Writing the software enable as 0 sets mask bit 16 in all six entries and drops an expiry that lands in the same cycle. The masks stay set after a later re-enable.
- R8: While the software enable is 0, any write to an entry (words 4..9) stores mask bit 16 as 1. Entry 0 keeps bits 17, 16 and 7:0, and entries 1..5 keep bits 16 and 7:0.
- R9: A reload value of 0, including the reset value, keeps the timer idle: the count stays 0 and no request is raised.
- R10: The current-count register is read-only, and a write to it leaves the readout unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Hardware enable of the interrupt unit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench targets the scrambled divide code. A design that used the contiguous low bits, or honoured bit 2, would expire after the wrong number of cycles. It also checks that a reload write in mid-count truly restarts: a design that only updated the reload value would fire at the old deadline. Periodic runs check that the spacing between requests is exact and that a reload of 0 stops the run. The masking rules are checked at the read port: a design that forgot to force masks when disabled, or fired from a masked entry or without the hardware enable, would show a stray request or a clear bit 16.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;
   // word addresses; entry 0 is the timer entry
   localparam int ADDR_CFG  = 0;
   localparam int ADDR_DIV  = 1;
   localparam int ADDR_LOAD = 2;
   localparam int ADDR_CUR  = 3;
   localparam int ADDR_ENT0 = 4;

   localparam int BIT_ON    = 0;
   localparam int BIT_MASK  = 16;
   localparam int BIT_PER   = 17;
   localparam int VEC_W     = 8;
   localparam int CODE_W    = 3;
   // prescaler must hold the largest divisor minus one
   localparam int PRE_W     = (1 << CODE_W) - 1;

   // scrambled code: bits 3,1,0; exponent wraps modulo 8
   function automatic logic [CODE_W-1:0] div_shift(input logic [3:0] raw);
      logic [CODE_W-1:0] code;
      code = {raw[3], raw[1], raw[0]};
      return code + CODE_W'(1);
   endfunction
endpackage

// File: rtl/vtimer_regs.sv
module vtimer_regs
   import vtimer_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_ENT = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [31:0]                   wdata,
   input  logic [CNT_W-1:0]              cur_cnt,
   output logic                          sw_on,
   output logic [CODE_W-1:0]             shift,
   output logic [CNT_W-1:0]              load_val,
   output logic                          load_wr,
   output logic                          off_wr,
   output logic [NUM_ENT-1:0][VEC_W-1:0] ent_vec,
   output logic [NUM_ENT-1:0]            ent_mask,
   output logic [NUM_ENT-1:0]            ent_per,
   output logic [31:0]                   rdata
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(ADDR_DIV);
   localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(ADDR_LOAD);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(ADDR_CUR);

   logic [3:0] div_q;

   assign load_wr = wr && (addr == A_LOAD);
   assign off_wr  = wr && (addr == A_CFG) && !wdata[BIT_ON];
   assign shift   = div_shift(div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_on    <= 1'b0;
         div_q    <= '0;
         load_val <= '0;
      end else if (wr) begin
         if (addr == A_CFG)  sw_on    <= wdata[BIT_ON];
         if (addr == A_DIV)  div_q    <= wdata[3:0];
         if (addr == A_LOAD) load_val <= wdata[CNT_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(ADDR_ENT0 + i);
      logic             hit;
      logic [VEC_W-1:0] vec_q;
      logic             msk_q;

      assign hit = wr && (addr == A_ME);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_q <= '0;
            msk_q <= 1'b1;
         end else if (off_wr) begin
            msk_q <= 1'b1;
         end else if (hit) begin
            vec_q <= wdata[VEC_W-1:0];
            msk_q <= wdata[BIT_MASK] | ~sw_on;
         end
      end

      if (i == 0) begin : g_timer
         logic per_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  per_q <= 1'b0;
            else if (hit) per_q <= wdata[BIT_PER];
         end
         assign ent_per[i] = per_q;
      end else begin : g_plain
         assign ent_per[i] = 1'b0;
      end

      assign ent_vec[i]  = vec_q;
      assign ent_mask[i] = msk_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CFG)  rdata = {31'b0, sw_on};
      if (addr == A_DIV)  rdata = {28'b0, div_q};
      if (addr == A_LOAD) rdata = 32'(load_val);
      if (addr == A_CUR)  rdata = 32'(cur_cnt);
      for (int i = 0; i < NUM_ENT; i++) begin
         if (addr == ADDR_W'(ADDR_ENT0 + i))
            rdata = {14'b0, ent_per[i], ent_mask[i], 8'b0, ent_vec[i]};
      end
   end
endmodule

// File: rtl/vtimer_prescale.sv
module vtimer_prescale
   import vtimer_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] shift,
   output logic              tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W:0]   span;
   logic [PRE_W-1:0] lim;

   assign span = (PRE_W+1)'(1) << shift;
   assign lim  = PRE_W'(span - (PRE_W+1)'(1));
   // >= keeps a shrinking divisor from stalling the count
   assign tick = (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (tick)    pre_q <= '0;
      else              pre_q <= pre_q + PRE_W'(1);
   end
endmodule

// File: rtl/vtimer_count.sv
module vtimer_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign expire = tick && !load && (cur == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (load) begin
         cur <= load_val;
      end else if (tick && (cur != '0)) begin
         if (cur == ONE) cur <= periodic ? load_val : '0;
         else            cur <= cur - ONE;
      end
   end
endmodule

// File: rtl/vtimer.sv
module vtimer
   import vtimer_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_ENT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_valid,
   output logic [VEC_W-1:0]  irq_vector
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("vtimer: CNT_W must lie in 2..32");
   end
   if (NUM_ENT < 1) begin : g_bad_ent
      $error("vtimer: NUM_ENT must be at least 1");
   end
   if (ADDR_ENT0 + NUM_ENT > (1 << ADDR_W)) begin : g_bad_addr
      $error("vtimer: ADDR_W too small for the entry table");
   end

   logic                          sw_on, load_wr, off_wr, tick, expire, fire;
   logic [CODE_W-1:0]             shift;
   logic [CNT_W-1:0]              load_val, cur_cnt;
   logic [NUM_ENT-1:0][VEC_W-1:0] ent_vec;
   logic [NUM_ENT-1:0]            ent_mask, ent_per;

   vtimer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_ENT(NUM_ENT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .cur_cnt(cur_cnt), .sw_on(sw_on), .shift(shift), .load_val(load_val),
      .load_wr(load_wr), .off_wr(off_wr), .ent_vec(ent_vec), .ent_mask(ent_mask),
      .ent_per(ent_per), .rdata(reg_rdata)
   );

   vtimer_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .restart(load_wr), .shift(shift), .tick(tick)
   );

   vtimer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load_wr), .load_val(reg_wdata[CNT_W-1:0]),
      .tick(tick), .periodic(ent_per[0]), .cur(cur_cnt), .expire(expire)
   );

   assign fire = expire && unit_en && sw_on && !off_wr && !ent_mask[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid  <= fire;
         irq_vector <= fire ? ent_vec[0] : '0;
      end
   end
endmodule

// File: rtl/vtimer_chk.sv
module vtimer_chk #(
   parameter int CNT_W   = 32,
   parameter int NUM_ENT = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               unit_en,
   input logic               irq_valid,
   input logic [7:0]         irq_vector,
   input logic               sw_on,
   input logic [NUM_ENT-1:0] ent_mask,
   input logic [7:0]         tmr_vec,
   input logic [CNT_W-1:0]   cur_cnt,
   input logic [CNT_W-1:0]   load_val,
   input logic               load_wr
);
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ($past(unit_en) && $past(sw_on) && !$past(ent_mask[0]))); // R6

   AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector == $past(tmr_vec))); // R6

   AST_OFF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_on |-> (&ent_mask)); // R8

   AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_on) |-> (&ent_mask)); // R7

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cur_cnt) == '0 && !$past(load_wr)) |-> (cur_cnt == '0)); // R9

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load_wr) && cur_cnt != $past(cur_cnt)) |->
         (cur_cnt == $past(cur_cnt) - CNT_W'(1) || cur_cnt == $past(load_val)
          || cur_cnt == '0)); // R4
endmodule

bind vtimer vtimer_chk #(.CNT_W(CNT_W), .NUM_ENT(NUM_ENT)) u_chk (
   .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .irq_valid(irq_valid),
   .irq_vector(irq_vector), .sw_on(sw_on), .ent_mask(ent_mask),
   .tmr_vec(ent_vec[0]), .cur_cnt(cur_cnt), .load_val(load_val), .load_wr(load_wr)
);

// File: tb/vtimer_tb.sv
`timescale 1ns/1ps
module vtimer_tb;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          unit_en = 1'b1;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_valid;
   logic [7:0]    irq_vector;

   int unsigned cyc = 0;
   int checks = 0;
   int fails = 0;

   typedef struct {
      int unsigned cyc;
      logic [7:0]  vec;
      string       req;
   } exp_t;
   exp_t q[$];
   exp_t e;

   vtimer #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare requests against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].cyc < cyc) begin
            e = q.pop_front();
            checks++; fails++;
            $display("FAIL %s missing request: actual none, expected cycle %0d vec %h",
                     e.req, e.cyc, e.vec);
         end
         if (irq_valid) begin
            checks++;
            if (q.size() == 0) begin
               fails++;
               $display("FAIL R6 unexpected request: actual cycle %0d vec %h, expected none",
                        cyc, irq_vector);
            end else begin
               e = q.pop_front();
               if (e.cyc != cyc || e.vec != irq_vector) begin
                  fails++;
                  $display("FAIL %s request: actual cycle %0d vec %h, expected cycle %0d vec %h",
                           e.req, cyc, irq_vector, e.cyc, e.vec);
               end
            end
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d, output int unsigned wedge);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      wedge = cyc + 1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string req);
      reg_addr = AW'(a);
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         fails++;
         $display("FAIL %s read word %0d: actual %h expected %h", req, a, reg_rdata, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int div_of(input logic [3:0] r);
      logic [2:0] code;
      code = {r[3], r[1], r[0]};
      return 1 << ((int'(code) + 1) % 8);
   endfunction

   task automatic expect_irq(input int unsigned at, input logic [7:0] v, input string req);
      exp_t x;
      x.cyc = at; x.vec = v; x.req = req;
      q.push_back(x);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // one-shot run: set divider, load count, expect one request
   task automatic run_once(input logic [3:0] dv, input int n, input logic [7:0] v,
                           input string req);
      int unsigned w;
      wr(1, {28'b0, dv}, w);
      wr(2, n, w);
      expect_irq(w + n * div_of(dv), v, req);
      idle(n * div_of(dv) + 4);
      rd_chk(3, 0, "R4");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      summary();
   end

   initial begin
      int unsigned w, w2;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd_chk(0, 0, "R1");
      rd_chk(1, 0, "R1");
      rd_chk(2, 0, "R1");
      rd_chk(3, 0, "R1");
      for (int i = 0; i < 6; i++) rd_chk(4 + i, 32'h0001_0000, "R1");

      // R9 reset reload of 0: idle
      idle(20);
      rd_chk(3, 0, "R9");

      // R8 writes while disabled keep mask set
      wr(4, 32'h0000_0031, w);
      rd_chk(4, 32'h0001_0031, "R8");
      wr(6, 32'h0003_00AA, w);
      rd_chk(6, 32'h0001_00AA, "R8");

      // enable, unmask one-shot
      wr(0, 1, w);
      wr(4, 32'h0000_0041, w);
      rd_chk(4, 32'h0000_0041, "R6");

      // R3/R4 one-shot with divide by 1 (code 7 = bits 3,1,0 set)
      run_once(4'hB, 5, 8'h41, "R3");

      // R4 mid-count readout with divide by 2
      wr(1, 0, w);
      wr(2, 3, w);
      expect_irq(w + 6, 8'h41, "R2");
      idle(2);
      rd_chk(3, 2, "R4");
      idle(8);
      rd_chk(3, 0, "R4");

      // R2 bit 2 ignored, other codes
      run_once(4'h4, 3, 8'h41, "R2");
      run_once(4'h9, 2, 8'h41, "R2");
      run_once(4'h3, 4, 8'h41, "R2");
      run_once(4'h2, 3, 8'h41, "R2");

      // R5 periodic, then stop with reload 0 (R9)
      wr(4, 32'h0002_0052, w);
      wr(1, 32'hB, w);
      wr(2, 4, w);
      expect_irq(w + 4, 8'h52, "R5");
      expect_irq(w + 8, 8'h52, "R5");
      expect_irq(w + 12, 8'h52, "R5");
      while (cyc < w + 13) @(negedge clk);
      wr(2, 0, w2);
      idle(20);
      rd_chk(3, 0, "R9");

      // R3 restart in mid-count cancels the old deadline
      wr(4, 32'h0000_0063, w);
      wr(2, 10, w);
      idle(4);
      wr(2, 3, w2);
      expect_irq(w2 + 3, 8'h63, "R3");
      idle(15);

      // R10 count register read-only
      wr(3, 32'h0000_1234, w);
      rd_chk(3, 0, "R10");

      // R6 masked entry: counts but no request
      wr(4, 32'h0001_0060, w);
      wr(2, 3, w);
      idle(1);
      rd_chk(3, 2, "R6");
      idle(6);
      rd_chk(3, 0, "R6");

      // R6 hardware enable low: no request
      wr(4, 32'h0000_0041, w);
      unit_en = 1'b0;
      wr(2, 3, w);
      idle(8);
      unit_en = 1'b1;
      rd_chk(3, 0, "R6");

      // R7 disabling masks all entries and drops the pending expiry
      wr(2, 50, w);
      idle(10);
      wr(0, 0, w);
      for (int i = 0; i < 6; i++) begin
         reg_addr = AW'(4 + i);
         #1;
         checks++;
         if (reg_rdata[16] !== 1'b1) begin
            fails++;
            $display("FAIL R7 entry %0d mask: actual %b expected 1", i, reg_rdata[16]);
         end
      end
      idle(60);
      wr(0, 1, w);
      rd_chk(4, 32'h0001_0041, "R7");

      idle(5);
      while (q.size() > 0) begin
         e = q.pop_front();
         checks++; fails++;
         $display("FAIL %s missing request: actual none, expected cycle %0d vec %h",
                  e.req, e.cyc, e.vec);
      end
      summary();
   end
endmodule